// File: doc/BRIEF.md
# Dual Masked Calendar Alarm Matcher

This block watches a running calendar time held in BCD (seconds, minutes, hours, date, month and day of week) and compares it with two independent alarm settings. Each alarm holds one byte per time field. The top bit of each byte arms that field, and the lower bits hold the BCD value the field must equal. Only armed fields take part in the comparison. Arming a subset of fields gives a repeating alarm. For example, an alarm with seconds, minutes and hours armed fires once a day, and one with month and date armed as well fires once a year.

The comparison is made only on a clock edge where the one-cycle `tick` strobe is high. On a match, the block sets a sticky flag for that alarm. The flag stays set until a write to the status port clears it. A separate interrupt-enable register gates each flag onto one shared interrupt line. The time counter that produces the BCD values and the bus that feeds the write ports belong to the surrounding logic.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset every alarm byte is 00h, so every field is disarmed. Both flags are 0, both interrupt enables are 0, and `irq` is 0.
- R2: Bit 7 of an alarm byte arms its field. An alarm matches only when every armed field equals the current time value. A field that is not armed has no effect on the result.
- R3: Only the value bits of a field are compared, and all other bits are ignored on both the alarm side and the time side. The value bits are 6:0 for seconds and minutes, 5:0 for hours (bit 6 is ignored), 5:0 for date, 4:0 for month, and 2:0 for day of week.
- R4: An alarm write goes to the alarm chosen by `alm_wr_sel` (0 or 1). The field is chosen by `alm_wr_field`: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week. Field codes 6 and 7 change nothing.
- R5: Matching happens only on an edge where `tick` is 1. A match sets the flag at that same edge, so the flag reads 1 in the following cycle. With `tick` at 0 no flag is set.
- R6: An alarm with no armed field never matches.
- R7: Flags are sticky. A status write clears alarm 0's flag when data bit 5 is 1, and clears alarm 1's flag when data bit 6 is 1. If a clear and a new match land on the same edge, the flag stays set.
- R8: The two alarms are independent. Writing, matching or clearing one of them never changes the other's flag.
- R9: An interrupt-enable write loads bit 0 for alarm 0 and bit 1 for alarm 1. `irq` is 1 exactly when some flag is set and its enable is set, with no added delay after the flag register.
- R10: When an alarm write and a tick fall on the same edge, that tick is compared against the alarm contents held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe that requests a comparison |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_month | input | 8 | Current month, BCD |
| cur_wday | input | 8 | Current day of week, 0-6 |
| alm_wr | input | 1 | Alarm byte write strobe |
| alm_wr_sel | input | 1 | Target alarm index |
| alm_wr_field | input | 3 | Target field code |
| alm_wr_data | input | 8 | Arm bit 7 and BCD value |
| status_wr | input | 1 | Status write strobe (clears flags) |
| status_wr_data | input | 8 | Bit 5 clears alarm 0, bit 6 clears alarm 1 |
| ien_wr | input | 1 | Interrupt-enable write strobe |
| ien_wr_data | input | 2 | Per-alarm interrupt enables |
| alarm_flag | output | 2 | Sticky match flags |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted arm bit or a stored value with a wrong mask stays hidden until the next tick whose time hits the difference. At that tick it shows up as a flag that rises when it should not, or stays low when it should rise. The bench therefore drives time values drawn from a small set, so that armed and disarmed fields often agree and often disagree. It also compares both flags and `irq` against a bench model in every cycle. A flag register that loses its sticky state or misses a clear shows on the `alarm_flag` port one cycle after the edge in question. A wrong enable shows on `irq` in the same cycle.

// File: rtl/cal_alarm_pkg.sv
// Shared constants and helpers for the calendar alarm matcher.
// Assumes an 8-bit alarm byte: bit 7 arms the field, bits below hold BCD.
package cal_alarm_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 6;
    localparam int FSEL_W     = 3;
    localparam int FLAG_BASE  = 5;   // status bit of alarm 0's flag

    typedef enum logic [FSEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4,
        FLD_WDAY  = 3'd5
    } field_e;

    // Value bits that take part in comparison for each field code.
    function automatic logic [BYTE_W-1:0] value_mask(int idx);
        case (idx)
            FLD_SEC, FLD_MIN:   value_mask = 8'h7F;
            FLD_HOUR, FLD_DATE: value_mask = 8'h3F;
            FLD_MONTH:          value_mask = 8'h1F;
            default:            value_mask = 8'h07;
        endcase
    endfunction

endpackage

// File: rtl/cal_alarm_field.sv
// One alarm field slot: stores arm bit and masked BCD value and reports
// whether the current time value equals the stored one.
// Assumes the write strobe is already qualified by alarm selection.
module cal_alarm_field
    import cal_alarm_pkg::*;
#(
    parameter int FIELD_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FSEL_W-1:0] wr_field,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] cur_val,
    output logic              armed,
    output logic              same
);

    localparam logic [BYTE_W-1:0] VMASK = value_mask(FIELD_IDX);

    logic              arm_q;
    logic [BYTE_W-2:0] val_q;

    // Load arm bit and masked value when this field code is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            val_q <= '0;
        end else if (wr_en && wr_field == FSEL_W'(FIELD_IDX)) begin
            arm_q <= wr_data[BYTE_W-1];
            val_q <= wr_data[BYTE_W-2:0] & VMASK[BYTE_W-2:0];
        end
    end

    // Equality over value bits only.
    always_comb begin
        armed = arm_q;
        same  = ((cur_val ^ {1'b0, val_q}) & VMASK) == '0;
    end

endmodule

// File: rtl/cal_alarm_unit.sv
// One complete alarm: a slot per time field and the combined hit.
// Hit needs at least one armed field and every armed field equal.
module cal_alarm_unit
    import cal_alarm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [FSEL_W-1:0]            wr_field,
    input  logic [BYTE_W-1:0]            wr_data,
    input  logic [NUM_FIELDS*BYTE_W-1:0] cur_time,
    output logic                         hit
);

    logic [NUM_FIELDS-1:0] armed;
    logic [NUM_FIELDS-1:0] same;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        cal_alarm_field #(
            .FIELD_IDX (f)
        ) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_field (wr_field),
            .wr_data  (wr_data),
            .cur_val  (cur_time[f*BYTE_W +: BYTE_W]),
            .armed    (armed[f]),
            .same     (same[f])
        );
    end

    // Reduce per-field results to a single alarm hit.
    always_comb begin
        hit = (|armed) && (&(~armed | same));
    end

endmodule

// File: rtl/cal_alarm_flags.sv
// Sticky alarm flags, interrupt enables and the interrupt line.
// Assumes FLAG_BASE + NUM_ALARMS <= 8 so flag bits fit the status byte.
module cal_alarm_flags
    import cal_alarm_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [NUM_ALARMS-1:0] hit,
    input  logic                  clr_wr,
    input  logic [BYTE_W-1:0]     clr_data,
    input  logic                  ien_wr,
    input  logic [NUM_ALARMS-1:0] ien_data,
    output logic [NUM_ALARMS-1:0] flag,
    output logic                  irq
);

    localparam logic [BYTE_W-1:0] CLR_FIELD =
        BYTE_W'(((1 << NUM_ALARMS) - 1) << FLAG_BASE);

    logic [NUM_ALARMS-1:0] flag_q;
    logic [NUM_ALARMS-1:0] ien_q;
    logic [NUM_ALARMS-1:0] clr_vec;
    logic [NUM_ALARMS-1:0] set_vec;

    // Decode clear requests and qualified matches.
    always_comb begin
        clr_vec = clr_wr ? NUM_ALARMS'((clr_data & CLR_FIELD) >> FLAG_BASE) : '0;
        set_vec = tick ? hit : '0;
    end

    // Flags: clear first, a same-edge match wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_vec) | set_vec;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_data;
    end

    // Gate flags onto the shared interrupt.
    always_comb begin
        flag = flag_q;
        irq  = |(flag_q & ien_q);
    end

endmodule

// File: rtl/cal_alarm_match.sv
// Top: dual masked calendar alarm matcher. Packs the time inputs,
// routes alarm writes by index and collects hits into sticky flags.
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter  int NUM_ALARMS = 2,
    localparam int ASEL_W     = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [7:0]            cur_sec,
    input  logic [7:0]            cur_min,
    input  logic [7:0]            cur_hour,
    input  logic [7:0]            cur_date,
    input  logic [7:0]            cur_month,
    input  logic [7:0]            cur_wday,
    input  logic                  alm_wr,
    input  logic [ASEL_W-1:0]     alm_wr_sel,
    input  logic [2:0]            alm_wr_field,
    input  logic [7:0]            alm_wr_data,
    input  logic                  status_wr,
    input  logic [7:0]            status_wr_data,
    input  logic                  ien_wr,
    input  logic [NUM_ALARMS-1:0] ien_wr_data,
    output logic [NUM_ALARMS-1:0] alarm_flag,
    output logic                  irq
);

    logic [NUM_FIELDS*BYTE_W-1:0] cur_time;
    logic [NUM_ALARMS-1:0]        hit;

    // Pack the time fields in field-code order.
    always_comb begin
        cur_time = {cur_wday, cur_month, cur_date, cur_hour, cur_min, cur_sec};
    end

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        cal_alarm_unit u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (alm_wr && alm_wr_sel == ASEL_W'(a)),
            .wr_field (alm_wr_field),
            .wr_data  (alm_wr_data),
            .cur_time (cur_time),
            .hit      (hit[a])
        );
    end

    cal_alarm_flags #(
        .NUM_ALARMS (NUM_ALARMS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hit      (hit),
        .clr_wr   (status_wr),
        .clr_data (status_wr_data),
        .ien_wr   (ien_wr),
        .ien_data (ien_wr_data),
        .flag     (alarm_flag),
        .irq      (irq)
    );

endmodule

// File: rtl/cal_alarm_checker.sv
// Port-level properties of the alarm matcher, bound into every instance.
module cal_alarm_checker #(
    parameter int NUM_ALARMS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  status_wr,
    input logic [7:0]            status_wr_data,
    input logic [NUM_ALARMS-1:0] alarm_flag,
    input logic                  irq
);

    // R1: first active cycle after reset shows clean outputs.
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (alarm_flag == '0 && !irq));

    // R9: interrupt only with some flag set.
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (alarm_flag != '0));

    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_chk
        // R7: a set flag survives unless its clear bit is written.
        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (alarm_flag[g] && !(status_wr && status_wr_data[5+g])) |=> alarm_flag[g]);

        // R7: a clear without a tick drops the flag.
        p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (status_wr && status_wr_data[5+g] && !tick) |=> !alarm_flag[g]);

        // R5: no rising flag without a tick on the previous edge.
        p_set_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> !$rose(alarm_flag[g]));
    end

endmodule

bind cal_alarm_match cal_alarm_checker #(
    .NUM_ALARMS (NUM_ALARMS)
) u_cal_alarm_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .status_wr      (status_wr),
    .status_wr_data (status_wr_data),
    .alarm_flag     (alarm_flag),
    .irq            (irq)
);

// File: tb/test_cal_alarm_match.sv
`timescale 1ns/1ps
module test_cal_alarm_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] tm [6];
    logic       alm_wr = 1'b0;
    logic       alm_wr_sel = 1'b0;
    logic [2:0] alm_wr_field = '0;
    logic [7:0] alm_wr_data = '0;
    logic       status_wr = 1'b0;
    logic [7:0] status_wr_data = '0;
    logic       ien_wr = 1'b0;
    logic [1:0] ien_wr_data = '0;
    logic [1:0] alarm_flag;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_reg [2][6];
    logic [1:0] m_flag = '0;
    logic [1:0] m_ien = '0;

    always #2 clk = ~clk;

    cal_alarm_match i_cal_alarm_match (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .cur_sec        (tm[0]),
        .cur_min        (tm[1]),
        .cur_hour       (tm[2]),
        .cur_date       (tm[3]),
        .cur_month      (tm[4]),
        .cur_wday       (tm[5]),
        .alm_wr         (alm_wr),
        .alm_wr_sel     (alm_wr_sel),
        .alm_wr_field   (alm_wr_field),
        .alm_wr_data    (alm_wr_data),
        .status_wr      (status_wr),
        .status_wr_data (status_wr_data),
        .ien_wr         (ien_wr),
        .ien_wr_data    (ien_wr_data),
        .alarm_flag     (alarm_flag),
        .irq            (irq)
    );

    // R3 value bits per field code
    function automatic logic [7:0] fmask(int f);
        case (f)
            0, 1:    return 8'h7F;
            2, 3:    return 8'h3F;
            4:       return 8'h1F;
            default: return 8'h07;
        endcase
    endfunction

    // R2/R6 expected hit
    function automatic bit m_hit(int a);
        bit any = 0;
        bit ok = 1;
        for (int f = 0; f < 6; f++) begin
            if (m_reg[a][f][7]) begin
                any = 1;
                if ((tm[f] & fmask(f)) != (m_reg[a][f] & fmask(f))) ok = 0;
            end
        end
        return any && ok;
    endfunction

    task automatic model_step();
        bit [1:0] h;
        for (int a = 0; a < 2; a++) h[a] = tick && m_hit(a);   // R10: old contents
        for (int a = 0; a < 2; a++)
            if (status_wr && status_wr_data[5+a]) m_flag[a] = 1'b0;
        m_flag = m_flag | h;
        if (ien_wr) m_ien = ien_wr_data;
        if (alm_wr && alm_wr_field < 3'd6) m_reg[alm_wr_sel][alm_wr_field] = alm_wr_data;
    endtask

    task automatic check(string tag);
        logic exp_irq;
        exp_irq = |(m_flag & m_ien);
        checks++;
        if (alarm_flag !== m_flag || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s flag=%b exp=%b irq=%b exp=%b", tag, alarm_flag, m_flag, irq, exp_irq);
        end
    endtask

    task automatic idle();
        tick = 0; alm_wr = 0; status_wr = 0; ien_wr = 0;
    endtask

    task automatic cycle(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
        idle();
    endtask

    task automatic wr_alarm(bit sel, int fld, logic [7:0] d, string tag);
        alm_wr = 1; alm_wr_sel = sel; alm_wr_field = 3'(fld); alm_wr_data = d;
        cycle(tag);
    endtask

    task automatic clear(logic [7:0] d, string tag);
        status_wr = 1; status_wr_data = d;
        cycle(tag);
    endtask

    task automatic set_time(logic [7:0] v);
        for (int f = 0; f < 6; f++) tm[f] = v;
    endtask

    function automatic logic [7:0] pick();
        logic [7:0] vals [4] = '{8'h00, 8'h15, 8'h23, 8'h59};
        logic [7:0] v;
        v = vals[$urandom % 4];
        if ($urandom % 4 == 0) v = v | 8'(($urandom % 2) << 7);
        return v;
    endfunction

    initial begin
        #(60000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < 2; a++)
            for (int f = 0; f < 6; f++) m_reg[a][f] = 8'h00;
        set_time(8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset");

        // R6: all fields disarmed, time equals stored zeros
        tick = 1; cycle("R6 no armed field");

        // R2: arm seconds of alarm 0 only
        wr_alarm(0, 0, 8'hB0, "R4 write sec");
        tm[0] = 8'h30; tm[1] = 8'h11; tick = 1; cycle("R2 armed sec match");
        tm[0] = 8'h31; tick = 1; cycle("R7 sticky");
        clear(8'h20, "R7 clear alarm0");
        tick = 1; cycle("R2 armed field differs");

        // R9 and R7 set wins
        ien_wr = 1; ien_wr_data = 2'b01; cycle("R9 enable write");
        tm[0] = 8'h30; tick = 1; cycle("R9 irq raised");
        status_wr = 1; status_wr_data = 8'h20; tick = 1; cycle("R7 set wins over clear");
        tick = 0; cycle("R5 no tick");

        // R3: hour bit 6 ignored, alarm 1
        wr_alarm(0, 0, 8'h00, "R4 disarm sec");
        clear(8'h60, "R7 clear both");
        ien_wr = 1; ien_wr_data = 2'b11; cycle("R9 enable both");
        wr_alarm(1, 2, 8'hC5, "R3 hour with bit6");
        tm[2] = 8'h45; tick = 1; cycle("R3 hour masked match");
        tm[2] = 8'h06; tick = 1; cycle("R8 alarm0 untouched");

        // R4: codes 6 and 7 ignored
        wr_alarm(1, 2, 8'h00, "R4 disarm hour");
        clear(8'h40, "R7 clear alarm1");
        wr_alarm(1, 6, 8'hFF, "R4 code 6");
        wr_alarm(1, 7, 8'hFF, "R4 code 7");
        set_time(8'hFF); tick = 1; cycle("R4 invalid codes no effect");

        // R10: write and tick on same edge
        set_time(8'h00); tm[1] = 8'h22;
        alm_wr = 1; alm_wr_sel = 0; alm_wr_field = 3'd1; alm_wr_data = 8'hA2; tick = 1;
        cycle("R10 old contents used");
        tick = 1; cycle("R10 new contents next tick");
        tm[1] = 8'h22; tick = 0; clear(8'h20, "R5 clear then no tick");
        cycle("R5 held match without tick");

        // R8 random mix
        for (int i = 0; i < 4000; i++) begin
            for (int f = 0; f < 6; f++) tm[f] = pick();
            tick = ($urandom % 2) == 0;
            if ($urandom % 4 == 0) begin
                alm_wr = 1; alm_wr_sel = 1'($urandom % 2);
                alm_wr_field = 3'($urandom % 8);
                alm_wr_data = ($urandom % 3 == 0) ? pick() : (pick() | 8'h80);
            end
            if ($urandom % 8 == 0) begin
                status_wr = 1; status_wr_data = 8'($urandom);
            end
            if ($urandom % 16 == 0) begin
                ien_wr = 1; ien_wr_data = 2'($urandom);
            end
            cycle("R8 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule